// File: doc/BRIEF.md
# Soft Switch and Keyboard Latch Unit

This unit sits on the low byte of the I/O page address and turns reads and writes there into single-bit mode switches. The switches select memory banking, the character set and the display mode. It also holds the most recent key code in a latch with a "new key" strobe in bit 7. It returns status bytes that carry one flag in bit 7. It raises a one-cycle pulse when a display-affecting switch really changes value, so that a video pipeline can rebuild its mode.

Each access is a single-cycle strobe (`rdStb` or `wrStb`) with the page offset on `ioAddr`. The switch vector, the read data and the mode-change pulse are all registered. They present the result of an access in the cycle after the clock edge that sampled it. Key events come from a keyboard scanner as a one-cycle `keyValid` with a 7-bit code. A separate `keyDown` level reports whether any key is held.

Top module: `soft_switch_unit`

## Requirements
- R1: After reset the switch vector is 0x0100, so only TEXT is set. `modeChange` is 0 and `rdData` is 0x00. Switch bit positions are: 0 80STORE, 1 AUXREAD, 2 AUXWRITE, 3 INTCXROM, 4 ALTZP, 5 SLOTC3ROM, 6 80COL, 7 ALTCHAR, 8 TEXT, 9 MIXED, 10 PAGE2, 11 HIRES, 12 DBLHIRES.
- R2: Offsets 0x00–0x0B form pairs for bits 0 to 5 in order: offset 2k clears bit k and offset 2k+1 sets it. Only writes act on these bits; a read of those offsets leaves them unchanged.
- R3: Offsets 0x0C/0x0D clear/set 80COL and 0x0E/0x0F clear/set ALTCHAR, on a read or a write.
- R4: Offsets 0x50/0x51 clear/set TEXT, 0x52/0x53 MIXED, 0x54/0x55 PAGE2 and 0x56/0x57 HIRES. Offset 0x5E sets DBLHIRES and 0x5F clears it. Each acts on a read or a write.
- R5: A `keyValid` pulse loads the latch with `{1'b1, keyCode}`. A read of any offset 0x00–0x0F returns the latch byte as it was before the access, including an access that also toggles a switch.
- R6: A read of offset 0x10 returns 0x80 when `keyDown` is high and 0x00 when it is low, and clears latch bit 7.
- R7: A write to any offset 0x10–0x1F clears latch bit 7 and leaves the code bits unchanged.
- R8: A read returns 0x80 when the matching flag is set and 0x00 otherwise. The offsets map as follows: 0x13 AUXREAD, 0x14 AUXWRITE, 0x15 INTCXROM, 0x16 ALTZP, 0x17 SLOTC3ROM, 0x18 80STORE, 0x1A TEXT, 0x1B MIXED, 0x1C PAGE2, 0x1D HIRES, 0x1E ALTCHAR and 0x1F 80COL. Reads of 0x11, 0x12 and 0x19 return 0x00.
- R9: Reads of 0x50–0x5F return 0xFF. Reads of offsets not named in R2–R8 return 0x00. Accesses to those offsets change no switch.
- R10: `modeChange` is high for one cycle after an access that changes 80COL, TEXT, MIXED, PAGE2, HIRES or DBLHIRES. It stays low when the access leaves the bit at its old value, when only ALTCHAR or a bit of R2 changes, and when PAGE2 changes while 80COL is set.
- R11: Switches, `rdData` and `modeChange` update at the clock edge that samples the strobe, and `rdData` holds between reads. A `keyValid` at the same edge as a latch clear loads the latch with bit 7 set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ioAddr | input | 8 | Offset within the I/O page |
| rdStb | input | 1 | Read access this cycle |
| wrStb | input | 1 | Write access this cycle |
| keyValid | input | 1 | New key code present |
| keyCode | input | 7 | Key code |
| keyDown | input | 1 | Any key held |
| switches | output | 13 | Mode switch vector (R1 positions) |
| rdData | output | 8 | Registered read data |
| modeChange | output | 1 | One-cycle display-mode change pulse |

## Verification
The switch vector is visible directly at the ports, so a wrong decode shows in the cycle after the access as a wrong or missing bit flip. A switch that moves on a read when it should not also shows there. A corrupted latch or status mux stays hidden until the next read of the affected offset. The bench therefore follows each key event and latch clear with a read of C000-range or C010. A mis-gated mode pulse shows the same cycle as the switch change. Back-to-back toggles of the same switch expose a pulse raised without a real change in value.

// File: rtl/ssk_pkg.sv
package ssk_pkg;
  localparam int SW_W  = 13;
  localparam int IDX_W = 4;

  typedef enum logic [IDX_W-1:0] {
    SW_STORE80 = 4'd0, SW_AUXRD = 4'd1, SW_AUXWR = 4'd2, SW_INTCX = 4'd3,
    SW_ALTZP = 4'd4, SW_SLOTC3 = 4'd5, SW_COL80 = 4'd6, SW_ALTCHR = 4'd7,
    SW_TEXT = 4'd8, SW_MIXED = 4'd9, SW_PAGE2 = 4'd10, SW_HIRES = 4'd11,
    SW_DBLHI = 4'd12
  } swIdx_e;

  typedef enum logic [2:0] {
    RD_ZERO, RD_LATCH, RD_ANYKEY, RD_STATUS, RD_FLOAT
  } rdSel_e;

  typedef struct packed {
    logic   swEn;
    swIdx_e swIdx;
    logic   swVal;
    logic   kbdClr;
    logic   rdEn;
    rdSel_e rdSel;
    swIdx_e statIdx;
  } ctlStrb_t;

  localparam logic [SW_W-1:0] RESET_SW  = SW_W'(1) << SW_TEXT;
  localparam logic [SW_W-1:0] DISP_MASK = (SW_W'(1) << SW_COL80) | (SW_W'(1) << SW_TEXT)
                                        | (SW_W'(1) << SW_MIXED) | (SW_W'(1) << SW_PAGE2)
                                        | (SW_W'(1) << SW_HIRES) | (SW_W'(1) << SW_DBLHI);
endpackage

// File: rtl/ssk_ctrl.sv
module ssk_ctrl
  import ssk_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic [ADDR_W-1:0] ioAddr,
  input  logic              rdStb,
  input  logic              wrStb,
  output ctlStrb_t          strb
);
  localparam int NIB = 4;

  logic [NIB-1:0] hiNib;
  logic [NIB-1:0] loNib;
  logic           anyAcc;
  logic           isRd;

  assign hiNib  = ioAddr[2*NIB-1:NIB];
  assign loNib  = ioAddr[NIB-1:0];
  assign anyAcc = rdStb | wrStb;
  assign isRd   = rdStb & ~wrStb;

  always_comb begin
    strb         = '0;
    strb.swIdx   = SW_STORE80;
    strb.statIdx = SW_STORE80;
    strb.rdSel   = RD_ZERO;
    strb.rdEn    = isRd;
    case (hiNib)
      4'h0: begin
        strb.rdSel = RD_LATCH;
        strb.swVal = loNib[0];
        if (loNib[3:1] <= 3'd5) begin
          strb.swEn  = wrStb;
          strb.swIdx = swIdx_e'({1'b0, loNib[3:1]});
        end else begin
          strb.swEn  = anyAcc;
          strb.swIdx = loNib[1] ? SW_ALTCHR : SW_COL80;
        end
      end
      4'h1: begin
        strb.kbdClr = wrStb | (isRd && loNib == 4'h0);
        strb.rdSel  = RD_STATUS;
        case (loNib)
          4'h0: strb.rdSel = RD_ANYKEY;
          4'h3: strb.statIdx = SW_AUXRD;
          4'h4: strb.statIdx = SW_AUXWR;
          4'h5: strb.statIdx = SW_INTCX;
          4'h6: strb.statIdx = SW_ALTZP;
          4'h7: strb.statIdx = SW_SLOTC3;
          4'h8: strb.statIdx = SW_STORE80;
          4'hA: strb.statIdx = SW_TEXT;
          4'hB: strb.statIdx = SW_MIXED;
          4'hC: strb.statIdx = SW_PAGE2;
          4'hD: strb.statIdx = SW_HIRES;
          4'hE: strb.statIdx = SW_ALTCHR;
          4'hF: strb.statIdx = SW_COL80;
          default: strb.rdSel = RD_ZERO;
        endcase
      end
      4'h5: begin
        strb.rdSel = RD_FLOAT;
        if (!loNib[3]) begin
          strb.swEn  = anyAcc;
          strb.swIdx = swIdx_e'(IDX_W'(SW_TEXT) + {2'b00, loNib[2:1]});
          strb.swVal = loNib[0];
        end else if (loNib[3:1] == 3'b111) begin
          strb.swEn  = anyAcc;
          strb.swIdx = SW_DBLHI;
          strb.swVal = ~loNib[0];
        end
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/ssk_datapath.sv
module ssk_datapath
  import ssk_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int KEY_W  = 7,
  parameter logic [DATA_W-1:0] FLOAT_VAL = 8'hFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  ctlStrb_t          strb,
  input  logic              keyValid,
  input  logic [KEY_W-1:0]  keyCode,
  input  logic              keyDown,
  output logic [SW_W-1:0]   switches,
  output logic [DATA_W-1:0] rdData,
  output logic              modeChange
);
  localparam int FLAG_BIT = DATA_W - 1;

  logic [DATA_W-1:0] kbdLatch;
  logic [SW_W-1:0]   swNext;
  logic              bitChanges;
  logic              pulseNext;
  logic [DATA_W-1:0] rdNext;

  always_comb begin
    swNext = switches;
    if (strb.swEn) swNext[strb.swIdx] = strb.swVal;
  end

  assign bitChanges = strb.swEn && (switches[strb.swIdx] != strb.swVal);
  assign pulseNext  = bitChanges && DISP_MASK[strb.swIdx]
                      && !(strb.swIdx == SW_PAGE2 && switches[SW_COL80]);

  always_comb begin
    rdNext = '0;
    case (strb.rdSel)
      RD_LATCH:  rdNext = kbdLatch;
      RD_ANYKEY: rdNext[FLAG_BIT] = keyDown;
      RD_STATUS: rdNext[FLAG_BIT] = switches[strb.statIdx];
      RD_FLOAT:  rdNext = FLOAT_VAL;
      default:   rdNext = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      switches   <= RESET_SW;
      kbdLatch   <= '0;
      rdData     <= '0;
      modeChange <= 1'b0;
    end else begin
      switches   <= swNext;
      modeChange <= pulseNext;
      if (strb.rdEn) rdData <= rdNext;
      if (keyValid) kbdLatch <= {1'b1, keyCode};
      else if (strb.kbdClr) kbdLatch[FLAG_BIT] <= 1'b0;
    end
  end

  // R5
  latch_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    keyValid |=> (kbdLatch[FLAG_BIT] && kbdLatch[KEY_W-1:0] == $past(keyCode)));

  // R7
  latch_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.kbdClr && !keyValid) |=> (!kbdLatch[FLAG_BIT] && $stable(kbdLatch[KEY_W-1:0])));

  // R10
  pulse_real_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
    modeChange |-> ((switches & DISP_MASK) != ($past(switches) & DISP_MASK)));

  // R11
  single_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(switches ^ $past(switches)) <= 1);
endmodule

// File: rtl/soft_switch_unit.sv
module soft_switch_unit
  import ssk_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter int KEY_W  = 7,
  parameter logic [DATA_W-1:0] FLOAT_VAL = 8'hFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] ioAddr,
  input  logic              rdStb,
  input  logic              wrStb,
  input  logic              keyValid,
  input  logic [KEY_W-1:0]  keyCode,
  input  logic              keyDown,
  output logic [SW_W-1:0]   switches,
  output logic [DATA_W-1:0] rdData,
  output logic              modeChange
);
  localparam int BANK_BITS = 6;

  ctlStrb_t strb;

  ssk_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .ioAddr(ioAddr), .rdStb(rdStb), .wrStb(wrStb), .strb(strb)
  );

  ssk_datapath #(.DATA_W(DATA_W), .KEY_W(KEY_W), .FLOAT_VAL(FLOAT_VAL)) u_dp (
    .clk(clk), .rst_n(rst_n), .strb(strb), .keyValid(keyValid),
    .keyCode(keyCode), .keyDown(keyDown), .switches(switches),
    .rdData(rdData), .modeChange(modeChange)
  );

  // R2
  bank_write_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(wrStb) |-> (switches[BANK_BITS-1:0] == $past(switches[BANK_BITS-1:0])));

  // R9
  float_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rdStb && !wrStb && ioAddr[7:4] == 4'h5) |-> (rdData == FLOAT_VAL));
endmodule

// File: tb/soft_switch_unit_bench.sv
module soft_switch_unit_bench;
  typedef struct {
    logic [12:0] sw;
    logic [7:0]  rd;
    bit          chkRd;
    logic        mc;
    string       tag;
  } item_t;

  logic clk = 0, rst_n = 0;
  logic [7:0] ioAddr = 0;
  logic rdStb = 0, wrStb = 0, keyValid = 0, keyDown = 0;
  logic [6:0] keyCode = 0;
  logic [12:0] switches;
  logic [7:0]  rdData;
  logic        modeChange;

  int compared = 0, mismatched = 0;
  bit finished = 0;
  item_t q[$];

  logic [12:0] mSw;
  logic [7:0]  mLatch;

  always #5 clk = ~clk;

  soft_switch_unit u_soft_switch_unit (
    .clk(clk), .rst_n(rst_n), .ioAddr(ioAddr), .rdStb(rdStb), .wrStb(wrStb),
    .keyValid(keyValid), .keyCode(keyCode), .keyDown(keyDown),
    .switches(switches), .rdData(rdData), .modeChange(modeChange)
  );

  task automatic fail(input string tag, input string what, input int act, input int exp);
    mismatched++;
    $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
  endtask

  // monitor
  always @(posedge clk) begin
    #1;
    while (q.size() > 0) begin
      item_t it;
      it = q.pop_front();
      compared++;
      if (switches !== it.sw) fail(it.tag, "switches", switches, it.sw);
      else if (modeChange !== it.mc) fail(it.tag, "modeChange", modeChange, it.mc);
      else if (it.chkRd && rdData !== it.rd) fail(it.tag, "rdData", rdData, it.rd);
    end
  end

  function automatic logic [7:0] statusOf(input logic [7:0] a);
    int b;
    case (a)
      8'h13: b = 1;  8'h14: b = 2;  8'h15: b = 3;  8'h16: b = 4;
      8'h17: b = 5;  8'h18: b = 0;  8'h1A: b = 8;  8'h1B: b = 9;
      8'h1C: b = 10; 8'h1D: b = 11; 8'h1E: b = 7;  8'h1F: b = 6;
      default: b = -1;
    endcase
    return (b >= 0 && mSw[b]) ? 8'h80 : 8'h00;
  endfunction

  task automatic doAcc(input logic [7:0] a, input bit wr, input string tag);
    item_t it;
    int idx;
    logic val;
    idx = -1; val = 0;
    if (a <= 8'h0B) begin if (wr) begin idx = a / 2; val = a[0]; end end
    else if (a <= 8'h0F) begin idx = (a < 8'h0E) ? 6 : 7; val = a[0]; end
    else if (a >= 8'h50 && a <= 8'h57) begin idx = 8 + (a - 8'h50) / 2; val = a[0]; end
    else if (a == 8'h5E) begin idx = 12; val = 1; end
    else if (a == 8'h5F) begin idx = 12; val = 0; end
    it.tag = tag; it.chkRd = !wr; it.mc = 0;
    if (a <= 8'h0F) it.rd = mLatch;
    else if (a == 8'h10) it.rd = keyDown ? 8'h80 : 8'h00;
    else if (a[7:4] == 4'h1) it.rd = statusOf(a);
    else if (a[7:4] == 4'h5) it.rd = 8'hFF;
    else it.rd = 8'h00;
    if (idx >= 0 && mSw[idx] != val) begin
      it.mc = (idx == 6 || idx >= 8) && !(idx == 10 && mSw[6]);
      mSw[idx] = val;
    end
    if ((wr && a[7:4] == 4'h1) || (!wr && a == 8'h10)) mLatch[7] = 0;
    it.sw = mSw;
    @(negedge clk);
    ioAddr = a; rdStb = !wr; wrStb = wr;
    q.push_back(it);
    @(negedge clk);
    rdStb = 0; wrStb = 0;
  endtask

  task automatic keyEvent(input logic [6:0] code, input bit down, input bit withClr, input string tag);
    item_t it;
    it.tag = tag; it.chkRd = 0; it.mc = 0; it.rd = 0; it.sw = mSw;
    mLatch = {1'b1, code};
    @(negedge clk);
    keyValid = 1; keyCode = code; keyDown = down;
    if (withClr) begin ioAddr = 8'h11; wrStb = 1; end
    q.push_back(it);
    @(negedge clk);
    keyValid = 0; wrStb = 0;
  endtask

  initial begin
    #1_000_000;
    if (!finished) begin
      mismatched++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    mSw = 13'h0100; mLatch = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    compared++;
    if (switches !== 13'h0100 || modeChange !== 0 || rdData !== 8'h00)
      fail("R1", "reset state", {switches, modeChange, rdData}, {13'h0100, 1'b0, 8'h00});

    keyEvent(7'h41, 1, 0, "R5 key load");
    doAcc(8'h00, 0, "R5 latch read");
    doAcc(8'h01, 1, "R2 set 80STORE");
    doAcc(8'h00, 0, "R2 read does not clear");
    doAcc(8'h03, 0, "R2 read does not set");
    doAcc(8'h18, 0, "R8 80STORE flag");
    doAcc(8'h10, 0, "R6 any key high");
    doAcc(8'h00, 0, "R6 strobe cleared");
    keyEvent(7'h5A, 0, 0, "R5 key load 2");
    doAcc(8'h10, 0, "R6 any key low");
    keyEvent(7'h33, 1, 0, "R5 key load 3");
    doAcc(8'h1F, 1, "R7 write clears strobe");
    doAcc(8'h05, 0, "R7 code kept");
    doAcc(8'h0D, 0, "R3 80COL set by read");
    doAcc(8'h0D, 1, "R10 no change no pulse");
    doAcc(8'h0F, 1, "R3 ALTCHAR set");
    doAcc(8'h55, 0, "R10 PAGE2 under 80COL");
    doAcc(8'h0C, 1, "R3 80COL clear");
    doAcc(8'h54, 0, "R10 PAGE2 pulse");
    doAcc(8'h55, 1, "R4 PAGE2 set");
    doAcc(8'h50, 1, "R4 TEXT clear");
    doAcc(8'h53, 0, "R4 MIXED set");
    doAcc(8'h57, 1, "R4 HIRES set");
    doAcc(8'h5E, 0, "R4 DBLHIRES set");
    doAcc(8'h0E, 0, "R3 ALTCHAR clear");
    for (int k = 0; k < 5; k++) doAcc(8'(2*k + 3), 1, "R2 set bank bit");
    for (int a = 8'h11; a <= 8'h1F; a++) doAcc(8'(a), 0, "R8 status read");
    doAcc(8'h5F, 1, "R4 DBLHIRES clear");
    doAcc(8'h02, 1, "R2 AUXREAD clear");
    doAcc(8'h13, 0, "R8 AUXREAD flag low");
    doAcc(8'h30, 1, "R9 unlisted write");
    doAcc(8'h30, 0, "R9 unlisted read");
    doAcc(8'h5A, 0, "R9 floating read");
    doAcc(8'h51, 0, "R4 TEXT set");
    keyEvent(7'h2C, 1, 1, "R11 key and clear");
    doAcc(8'h00, 0, "R11 key wins");
    doAcc(8'h1C, 0, "R11 rd update");
    @(negedge clk);
    compared++;
    if (rdData !== 8'h80) fail("R11", "rdData held", rdData, 8'h80);
    repeat (2) @(negedge clk);
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule